// File: doc/BRIEF.md
# Half-Duplex Collision Indicator with Self-Test

This block produces the collision indication of a 10/100 Ethernet PHY. In normal half-duplex operation it raises `col_o` while the local transmitter is enabled and the receive side reports carrier, and it keeps it raised for as long as both stay active. The receive carrier comes from another clock domain, so it passes through a flop synchroniser before it is combined with transmit enable. The output is registered in the block clock and has no fixed relationship to either line clock.

Full-duplex operation never reports a collision. A self-test input lets software check the collision path with no receive traffic. In that mode the receive carrier is ignored, and `col_o` follows `tx_en_i` with a programmable delay in bit-time ticks on the rising side and a short delay on the falling side. Both delays stay inside the bounds a MAC expects from such a test: 512 bit times to assert and 4 bit times to release.

Top module: `col_detect`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after it rises, `col_o` is 0.
- R2: With `full_duplex_i`=0 and `col_test_i`=0, `col_o` is 1 whenever `tx_en_i` and the synchronised carrier are both 1. After `rx_crs_i` rises with `tx_en_i` already high, `col_o` rises on the third clock edge and stays high while both remain high.
- R3: In the mode of R2, `col_o` is 0 whenever either input is 0. After `tx_en_i` falls, `col_o` falls on the next clock edge.
- R4: `full_duplex_i`=1 forces `col_o` to 0 from the next clock edge, in every mode and including the self-test. It also clears any self-test progress.
- R5: `rx_crs_i` passes through `SYNC_STAGES` (default 2) flops before it is used. Because of these flops, `col_o` is still 0 two edges after `rx_crs_i` rises.
- R6: With `col_test_i`=1 and `full_duplex_i`=0, `col_o` rises on the clock edge after the edge that samples the `TEST_DELAY`-th `bit_tick_i` pulse seen while `tx_en_i` is high. It does not rise before that. `TEST_DELAY` ranges from 1 to 512 and defaults to 64.
- R7: In the self-test, if `tx_en_i` falls before the assertion delay completes, the tick count starts again from zero.
- R8: In the self-test, `col_o` falls on the clock edge after the edge that samples the `REL_DELAY`-th tick seen with `tx_en_i` low. If `tx_en_i` returns high before that, the release count restarts. `REL_DELAY` is 1 or 2.
- R9: In the self-test, `rx_crs_i` has no effect on `col_o`.
- R10: When `col_test_i` falls, the self-test state is cleared. `col_o` then follows R2 and R3, and turning the test back on starts from an idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable from the MAC side |
| rx_crs_i | input | 1 | Receive carrier, asynchronous to clk_i |
| full_duplex_i | input | 1 | 1 selects full-duplex operation |
| col_test_i | input | 1 | 1 enables the collision self-test |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| col_o | output | 1 | Collision indication |

## Verification
The bench builds the block with `TEST_DELAY`=8 and `REL_DELAY`=2. With these values the exact assertion edge of the self-test, the restart after an aborted count and both release outcomes can be reached in a few dozen cycles. The bench drives `bit_tick_i` pulse by pulse, so it can check the cycles just before and just after each threshold. The default `SYNC_STAGES`=2 gives the three-edge carrier latency that the bench measures edge by edge.

// File: rtl/col_pkg.sv
package col_pkg;
  typedef enum logic {
    TST_IDLE   = 1'b0,
    TST_ACTIVE = 1'b1
  } tst_state_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TEST   = 2'd1,
    MODE_FDX    = 2'd2
  } col_mode_e;
endpackage

// File: rtl/col_sync.sv
module col_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/col_test_fsm.sv
module col_test_fsm
  import col_pkg::*;
#(
  parameter int unsigned TEST_DELAY = 64,
  parameter int unsigned REL_DELAY  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tx_en_i,
  input  logic tick_i,
  output logic test_col_o
);
  localparam int unsigned AW = $clog2(TEST_DELAY + 1);
  localparam int unsigned RW = $clog2(REL_DELAY + 1);
  localparam logic [AW-1:0] A_LAST = AW'(TEST_DELAY - 1);
  localparam logic [RW-1:0] R_LAST = RW'(REL_DELAY - 1);

  tst_state_e state_q, state_d;
  logic [AW-1:0] acnt_q, acnt_d;
  logic [RW-1:0] rcnt_q, rcnt_d;

  always_comb begin
    state_d = state_q;
    acnt_d  = acnt_q;
    rcnt_d  = rcnt_q;
    if (clr_i) begin
      state_d = TST_IDLE;
      acnt_d  = '0;
      rcnt_d  = '0;
    end else begin
      unique case (state_q)
        TST_IDLE: begin
          if (!tx_en_i) begin
            acnt_d = '0;
          end else if (tick_i) begin
            if (acnt_q == A_LAST) begin
              state_d = TST_ACTIVE;
              acnt_d  = '0;
              rcnt_d  = '0;
            end else begin
              acnt_d = acnt_q + 1'b1;
            end
          end
        end
        TST_ACTIVE: begin
          if (tx_en_i) begin
            rcnt_d = '0;
          end else if (tick_i) begin
            if (rcnt_q == R_LAST) begin
              state_d = TST_IDLE;
              rcnt_d  = '0;
            end else begin
              rcnt_d = rcnt_q + 1'b1;
            end
          end
        end
        default: state_d = TST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TST_IDLE;
      acnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      acnt_q  <= acnt_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign test_col_o = (state_q == TST_ACTIVE);
endmodule

// File: rtl/col_out_reg.sv
module col_out_reg
  import col_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_duplex_i,
  input  logic col_test_i,
  input  logic overlap_i,
  input  logic test_col_i,
  output logic col_o
);
  col_mode_e mode;
  logic      col_d, col_q;

  // full duplex outranks self-test
  always_comb begin
    if (full_duplex_i)   mode = MODE_FDX;
    else if (col_test_i) mode = MODE_TEST;
    else                 mode = MODE_NORMAL;
  end

  always_comb begin
    unique case (mode)
      MODE_FDX:  col_d = 1'b0;
      MODE_TEST: col_d = test_col_i;
      default:   col_d = overlap_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= 1'b0;
    else         col_q <= col_d;
  end

  assign col_o = col_q;
endmodule

// File: rtl/col_detect.sv
module col_detect #(
  parameter int unsigned TEST_DELAY  = 64,
  parameter int unsigned REL_DELAY   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic rx_crs_i,
  input  logic full_duplex_i,
  input  logic col_test_i,
  input  logic bit_tick_i,
  output logic col_o
);
  logic crs_s;
  logic test_col;
  logic test_clr;

  col_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_crs_i),
    .q_o    (crs_s)
  );

  assign test_clr = full_duplex_i | ~col_test_i;

  col_test_fsm #(
    .TEST_DELAY (TEST_DELAY),
    .REL_DELAY  (REL_DELAY)
  ) u_test (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (test_clr),
    .tx_en_i    (tx_en_i),
    .tick_i     (bit_tick_i),
    .test_col_o (test_col)
  );

  col_out_reg u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .full_duplex_i (full_duplex_i),
    .col_test_i    (col_test_i),
    .overlap_i     (tx_en_i & crs_s),
    .test_col_i    (test_col),
    .col_o         (col_o)
  );
endmodule

// File: rtl/col_detect_chk.sv
module col_detect_chk #(
  parameter int unsigned TEST_DELAY = 64,
  parameter int unsigned REL_DELAY  = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic full_duplex_i,
  input logic col_test_i,
  input logic bit_tick_i,
  input logic crs_s,
  input logic col_o
);
  logic [9:0] a_cnt, r_cnt;
  logic       cond_a, cond_r;

  assign cond_a = col_test_i && !full_duplex_i && tx_en_i;
  assign cond_r = col_test_i && !full_duplex_i && !tx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cnt <= '0;
      r_cnt <= '0;
    end else begin
      if (!cond_a)                          a_cnt <= '0;
      else if (bit_tick_i && a_cnt != '1)   a_cnt <= a_cnt + 1'b1;
      if (!cond_r)                          r_cnt <= '0;
      else if (bit_tick_i && r_cnt != '1)   r_cnt <= r_cnt + 1'b1;
    end
  end

  assert_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && !col_test_i && tx_en_i && crs_s) |=> col_o);

  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && !col_test_i && !(tx_en_i && crs_s)) |=> !col_o);

  assert_fdx_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_duplex_i |=> !col_o);

  assert_test_rise_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_a && a_cnt > 10'(TEST_DELAY)) |-> col_o);

  assert_test_release_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_r && r_cnt > 10'(REL_DELAY)) |-> !col_o);
endmodule

bind col_detect col_detect_chk #(
  .TEST_DELAY (TEST_DELAY),
  .REL_DELAY  (REL_DELAY)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_en_i       (tx_en_i),
  .full_duplex_i (full_duplex_i),
  .col_test_i    (col_test_i),
  .bit_tick_i    (bit_tick_i),
  .crs_s         (crs_s),
  .col_o         (col_o)
);

// File: tb/sim_col_detect.sv
module sim_col_detect;
  localparam int unsigned TD = 8;
  localparam int unsigned RD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, crs = 1'b0, fdx = 1'b0, tst = 1'b0, tick = 1'b0;
  logic col;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  col_detect #(.TEST_DELAY(TD), .REL_DELAY(RD), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .rx_crs_i(crs),
    .full_duplex_i(fdx), .col_test_i(tst), .bit_tick_i(tick), .col_o(col)
  );

  // {fdx, tst=0, tx, crs, expected}
  localparam logic [4:0] VEC [8] = '{
    5'b0_0_0_0_0, 5'b0_0_1_0_0, 5'b0_0_0_1_0, 5'b0_0_1_1_1,
    5'b1_0_1_1_0, 5'b0_0_1_1_1, 5'b1_0_0_1_0, 5'b0_0_1_1_1
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    repeat (n) begin
      tick = 1'b1;
      step(1);
      tick = 1'b0;
    end
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (col !== exp) begin
      errors++;
      $display("FAIL %s: col_o=%b expected %b at %0t", req, col, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1", 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1", 1'b0);

    // table walk, steady state in normal mode
    foreach (VEC[i]) begin
      fdx = VEC[i][4]; tst = VEC[i][3]; tx_en = VEC[i][2]; crs = VEC[i][1];
      step(4);
      chk(VEC[i][4] ? "R4" : (VEC[i][0] ? "R2" : "R3"), VEC[i][0]);
    end

    // R5 carrier latency, R2 rise on third edge
    fdx = 0; tst = 0; tx_en = 1; crs = 0;
    step(4);
    crs = 1;
    step(2);
    chk("R5", 1'b0);
    step(1);
    chk("R2", 1'b1);
    // R3 tx fall drops on next edge
    tx_en = 0;
    step(1);
    chk("R3", 1'b0);

    // self-test, carrier high must not matter (R9)
    tx_en = 0; crs = 1; tst = 1;
    step(2);
    tx_en = 1;
    pulse(TD - 1);
    step(2);
    chk("R9", 1'b0);
    chk("R6", 1'b0);
    pulse(1);
    chk("R6", 1'b0);
    step(1);
    chk("R6", 1'b1);

    // release with restart, R8
    tx_en = 0;
    pulse(1);
    step(2);
    chk("R8", 1'b1);
    tx_en = 1;
    step(1);
    tx_en = 0;
    pulse(RD - 1);
    step(2);
    chk("R8", 1'b1);
    pulse(1);
    chk("R8", 1'b1);
    step(1);
    chk("R8", 1'b0);

    // aborted count restarts, R7
    crs = 0;
    tx_en = 1;
    pulse(5);
    tx_en = 0;
    step(1);
    tx_en = 1;
    pulse(TD - 1);
    step(2);
    chk("R7", 1'b0);
    pulse(1);
    step(1);
    chk("R7", 1'b1);

    // full duplex outranks test, clears progress (R4)
    fdx = 1;
    step(1);
    chk("R4", 1'b0);
    pulse(TD + 2);
    chk("R4", 1'b0);
    fdx = 0;
    step(2);
    chk("R4", 1'b0);
    pulse(TD);
    step(1);
    chk("R4", 1'b1);

    // leaving test mode, R10
    tst = 0; crs = 0;
    step(2);
    chk("R10", 1'b0);
    crs = 1;
    step(4);
    chk("R10", 1'b1);
    crs = 0;
    tst = 1;
    step(2);
    chk("R10", 1'b0);
    pulse(TD - 1);
    step(1);
    chk("R10", 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule